// File: doc/BRIEF.md
# Prescaled low-frequency counter

This block is a 24-bit count-up timer paced by a slow tick that arrives as a one-cycle enable in the system clock domain (nominally 32768 ticks per second). A 12-bit division ratio sets how many ticks make one count. Several compare channels raise a one-cycle pulse when the count reaches their value. A channel can also take a snapshot of the count. A separate unit downstream turns the match and wrap pulses into interrupts or routed events.

Software or event routing drives the block through one-cycle command pulses: launch, halt, zero and preload, plus one snapshot pulse per channel. A write port reaches the division ratio, the auto-zero mask and the compare values. A read port returns any of these and the live count. Halt, zero and preload are held pending and act on the next slow tick. Launch acts at once. The division ratio in use is a private copy, refreshed only at a few defined moments.

A two-state controller sets the run state. In HALTED the count is frozen; on a launch pulse the transition "launch" enters COUNTING, reloads the private ratio copy and restarts the tick divider. In COUNTING the count advances; the transition "freeze" returns to HALTED on the first slow tick after a halt pulse.

Top module: `lfc_counter`

## Requirements
- R1: After reset the count, division ratio, auto-zero mask and every compare value read 0, the controller is HALTED, and no pulse is output.
- R2: The count wraps from 0xFFFFFF to 0x000000. The wrap pulse `evt_wrap` is high for one cycle, in the first cycle that the count reads 0.
- R3: In COUNTING the count rises by one on every (D+1)-th slow tick, where D is the private ratio copy. The divider phase is counted from the most recent launch, zero or preload. The tick on which the count rises is the last tick of that group.
- R4: The private ratio copy is loaded from the ratio register only on launch and when a pending zero or preload takes effect. A ratio write at any other time does not change the count rate.
- R5: A preload pulse sets the count to 0xFFFFF0 on the first slow tick after the pulse. The wrap then comes 16 increments later.
- R6: A halt pulse stops counting on the first slow tick after it, and the count holds its value. A later launch continues from the held value.
- R7: A launch pulse while COUNTING is ignored: it neither reloads the ratio copy nor restarts the divider phase.
- R8: `evt_match[n]` pulses for one cycle, in the first cycle the count reads the value, each time an increment brings the count to compare value n. This repeats on every pass. Writing a compare value equal to the current count, or reaching the value through zero or preload, gives no pulse.
- R9: When auto-zero mask bit n is set, a match on channel n makes the count read the match value until the next slow tick, then 0. The divider phase restarts and the ratio copy reloads at that tick.
- R10: A snapshot pulse on channel n copies the current count into compare value n at the next clock edge. A snapshot takes priority over a write to the same channel in the same cycle.
- R11: A zero pulse sets the count and divider phase to 0 on the first slow tick after it. If zero and preload are both pending, zero wins. A command that arrives in a cycle that carries a slow tick takes effect on the following tick. The tick that applies any pending command never increments the count.
- R12: Register addresses: 0 = division ratio (bits 11:0, upper bits read 0); 1 = auto-zero mask (bit n for channel n); 2 = live count (read only, writes ignored); 4+n = compare value n. Other addresses read 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_tick | input | 1 | One-cycle enable for each slow tick |
| task_run | input | 1 | Launch command pulse |
| task_halt | input | 1 | Halt command pulse (deferred) |
| task_zero | input | 1 | Zero command pulse (deferred) |
| task_preload | input | 1 | Preload-near-wrap command pulse (deferred) |
| task_snap | input | N_CC | Per-channel snapshot pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Register read data |
| evt_match | output | N_CC | Per-channel match pulses |
| evt_wrap | output | 1 | Count wrap pulse |

## Verification
A wrong divider phase or a stale ratio copy changes the cycle in which the count next moves. The live count read on every cycle therefore differs from the expected count within D+1 slow ticks. A pending command that is lost or applied a tick early gives a count that is wrong from the next slow tick on. A fault in the compare path gives a missing or extra match pulse on the first pass through the compare value, and with auto-zero set it also gives a wrong count one tick later. A snapshot error shows up on the next read of that compare register.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    localparam int DEF_CNT_W  = 24;
    localparam int DEF_PSC_W  = 12;
    localparam int DEF_ADDR_W = 4;
    localparam int DEF_N_CC   = 4;

    localparam int REG_RATIO  = 0;
    localparam int REG_ZMASK  = 1;
    localparam int REG_COUNT  = 2;
    localparam int REG_CMP0   = 4;

    typedef enum logic {
        ST_HALTED   = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_e;
endpackage

// File: rtl/lfc_prescale.sv
module lfc_prescale #(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             restart,
    input  logic [PSC_W-1:0] limit,
    output logic             step
);
    logic [PSC_W-1:0] phase_q;

    assign step = advance && (phase_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= step ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/lfc_cc_bank.sv
module lfc_cc_bank #(
    parameter int N_CC    = 4,
    parameter int CNT_W   = 24,
    parameter int ADDR_W  = 4,
    parameter int CC_BASE = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [CNT_W-1:0]      cnt_cur,
    input  logic [CNT_W-1:0]      cnt_inc,
    input  logic [N_CC-1:0]       snap,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    output logic [N_CC*CNT_W-1:0] cc_flat,
    output logic [N_CC-1:0]       match_now,
    output logic [N_CC-1:0]       hit
);
    for (genvar g = 0; g < N_CC; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CC_BASE + g);
        logic [CNT_W-1:0] cc_q;
        logic             hit_q;

        assign match_now[g] = step && (cnt_inc == cc_q);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cc_q  <= '0;
                hit_q <= 1'b0;
            end else begin
                hit_q <= match_now[g];
                if (snap[g]) begin
                    cc_q <= cnt_cur;
                end else if (wr_en && (wr_addr == MY_ADDR)) begin
                    cc_q <= wr_data;
                end
            end
        end

        assign cc_flat[g*CNT_W +: CNT_W] = cc_q;
        assign hit[g] = hit_q;
    end
endmodule

// File: rtl/lfc_counter.sv
module lfc_counter
    import lfc_pkg::*;
#(
    parameter int N_CC   = DEF_N_CC,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int PSC_W  = DEF_PSC_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lf_tick,
    input  logic              task_run,
    input  logic              task_halt,
    input  logic              task_zero,
    input  logic              task_preload,
    input  logic [N_CC-1:0]   task_snap,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [N_CC-1:0]   evt_match,
    output logic              evt_wrap
);
    localparam logic [CNT_W-1:0]  PRELOAD_VAL = ~(CNT_W'(15));
    localparam logic [ADDR_W-1:0] A_RATIO     = ADDR_W'(REG_RATIO);
    localparam logic [ADDR_W-1:0] A_ZMASK     = ADDR_W'(REG_ZMASK);
    localparam logic [ADDR_W-1:0] A_COUNT     = ADDR_W'(REG_COUNT);

    run_state_e state_q, state_d;

    logic [PSC_W-1:0]      ratio_q, shadow_q;
    logic [N_CC-1:0]       zmask_q;
    logic [CNT_W-1:0]      cnt_q, cnt_inc;
    logic                  pend_zero_q, pend_halt_q, pend_pre_q;
    logic                  wrap_q;
    logic                  running, launch, apply, reload, advance, step;
    logic                  auto_zero;
    logic [N_CC*CNT_W-1:0] cc_flat;
    logic [N_CC-1:0]       match_now;

    // pending commands act on the first slow tick that finds them set
    assign apply     = lf_tick && (pend_zero_q || pend_halt_q || pend_pre_q);
    assign reload    = launch || (apply && (pend_zero_q || pend_pre_q));
    assign advance   = lf_tick && running && !apply;
    assign cnt_inc   = cnt_q + 1'b1;
    assign auto_zero = |(match_now & zmask_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    // next state: launch / freeze
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:   if (task_run)               state_d = ST_COUNTING;
            ST_COUNTING: if (apply && pend_halt_q)   state_d = ST_HALTED;
        endcase
    end

    // state-decoded controls
    always_comb begin
        running = 1'b0;
        launch  = 1'b0;
        unique case (state_q)
            ST_HALTED:   launch  = task_run;
            ST_COUNTING: running = 1'b1;
        endcase
    end

    lfc_prescale #(.PSC_W(PSC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .restart (reload),
        .limit   (shadow_q),
        .step    (step)
    );

    lfc_cc_bank #(
        .N_CC    (N_CC),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W),
        .CC_BASE (REG_CMP0)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .cnt_cur   (cnt_q),
        .cnt_inc   (cnt_inc),
        .snap      (task_snap),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cc_flat   (cc_flat),
        .match_now (match_now),
        .hit       (evt_match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            ratio_q     <= '0;
            shadow_q    <= '0;
            zmask_q     <= '0;
            pend_zero_q <= 1'b0;
            pend_halt_q <= 1'b0;
            pend_pre_q  <= 1'b0;
            wrap_q      <= 1'b0;
        end else begin
            if (apply && pend_zero_q)      cnt_q <= '0;
            else if (apply && pend_pre_q)  cnt_q <= PRELOAD_VAL;
            else if (step)                 cnt_q <= cnt_inc;

            wrap_q <= step && (cnt_q == '1);

            if (reload) shadow_q <= ratio_q;

            pend_zero_q <= (pend_zero_q && !apply) || task_zero || auto_zero;
            pend_halt_q <= (pend_halt_q && !apply) || task_halt;
            pend_pre_q  <= (pend_pre_q  && !apply) || task_preload;

            if (wr_en && (wr_addr == A_RATIO)) ratio_q <= wr_data[PSC_W-1:0];
            if (wr_en && (wr_addr == A_ZMASK)) zmask_q <= wr_data[N_CC-1:0];
        end
    end

    assign evt_wrap = wrap_q;

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_RATIO) rd_data = CNT_W'(ratio_q);
        if (rd_addr == A_ZMASK) rd_data = CNT_W'(zmask_q);
        if (rd_addr == A_COUNT) rd_data = cnt_q;
        for (int i = 0; i < N_CC; i++) begin
            if (rd_addr == ADDR_W'(REG_CMP0 + i)) rd_data = cc_flat[i*CNT_W +: CNT_W];
        end
    end
endmodule

// File: rtl/lfc_counter_chk.sv
module lfc_counter_chk #(
    parameter int N_CC  = 4,
    parameter int CNT_W = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lf_tick,
    input logic                  running,
    input logic [CNT_W-1:0]      cnt,
    input logic                  evt_wrap,
    input logic [N_CC-1:0]       evt_match,
    input logic [N_CC*CNT_W-1:0] cc_flat
);
    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wrap |-> (cnt == '0));

    // R2
    wrap_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wrap |-> $past(lf_tick));

    // R11
    count_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> $past(lf_tick));

    // R6
    freeze_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(lf_tick));

    for (genvar g = 0; g < N_CC; g++) begin : g_m
        // R8
        match_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_match[g] |-> (cnt == $past(cc_flat[g*CNT_W +: CNT_W])));
    end
endmodule

bind lfc_counter lfc_counter_chk #(.N_CC(N_CC), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lf_tick   (lf_tick),
    .running   (running),
    .cnt       (cnt_q),
    .evt_wrap  (evt_wrap),
    .evt_match (evt_match),
    .cc_flat   (cc_flat)
);

// File: tb/lfc_counter_test.sv
`timescale 1ns/1ps
module lfc_counter_test;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lf_tick = 1'b0;
    logic          task_run = 1'b0, task_halt = 1'b0, task_zero = 1'b0, task_preload = 1'b0;
    logic [NC-1:0] task_snap = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [23:0]   wr_data = '0;
    logic [3:0]    rd_addr = 4'd2;
    logic [23:0]   rd_data;
    logic [NC-1:0] evt_match;
    logic          evt_wrap;

    int    n_tests = 0;
    int    n_fail = 0;
    int    wrap_seen = 0;
    int    tick_mode = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    lfc_counter #(.N_CC(NC)) uut (
        .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick),
        .task_run(task_run), .task_halt(task_halt), .task_zero(task_zero),
        .task_preload(task_preload), .task_snap(task_snap),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_match(evt_match), .evt_wrap(evt_wrap)
    );

    // expected-behaviour model, written from the requirements
    logic          m_run, m_pz, m_ph, m_pp, m_wrap;
    logic [11:0]   m_ratio, m_shadow, m_phase;
    logic [NC-1:0] m_zmask, m_evt;
    logic [23:0]   m_cnt;
    logic [23:0]   m_cc [NC];

    always @(posedge clk) begin : model
        logic ap, ln, st, rl, az;
        if (!rst_n) begin
            m_run <= 0; m_pz <= 0; m_ph <= 0; m_pp <= 0; m_wrap <= 0;
            m_ratio <= 0; m_shadow <= 0; m_phase <= 0; m_zmask <= 0; m_evt <= 0; m_cnt <= 0;
            for (int n = 0; n < NC; n++) m_cc[n] <= 0;
        end else begin
            ap = lf_tick && (m_pz || m_ph || m_pp);
            ln = !m_run && task_run;
            st = lf_tick && m_run && !ap && (m_phase == m_shadow);
            rl = ln || (ap && (m_pz || m_pp));
            az = 1'b0;
            for (int n = 0; n < NC; n++) begin
                m_evt[n] <= st && (m_cnt + 24'd1 == m_cc[n]);
                if (st && m_zmask[n] && (m_cnt + 24'd1 == m_cc[n])) az = 1'b1;
                if (task_snap[n]) m_cc[n] <= m_cnt;
                else if (wr_en && wr_addr == 4'(4 + n)) m_cc[n] <= wr_data;
            end
            m_wrap <= st && (m_cnt == 24'hFFFFFF);
            if (ap && m_pz)      m_cnt <= 0;
            else if (ap && m_pp) m_cnt <= 24'hFFFFF0;
            else if (st)         m_cnt <= m_cnt + 24'd1;
            if (rl) m_phase <= 0;
            else if (lf_tick && m_run && !ap) m_phase <= st ? 12'd0 : m_phase + 12'd1;
            if (rl) m_shadow <= m_ratio;
            if (ln) m_run <= 1;
            else if (ap && m_ph) m_run <= 0;
            m_pz <= (m_pz && !ap) || task_zero || az;
            m_ph <= (m_ph && !ap) || task_halt;
            m_pp <= (m_pp && !ap) || task_preload;
            if (wr_en && wr_addr == 4'd0) m_ratio <= wr_data[11:0];
            if (wr_en && wr_addr == 4'd1) m_zmask <= wr_data[NC-1:0];
        end
    end

    function automatic logic [23:0] exp_read(input logic [3:0] a);
        if (a == 4'd0) return {12'd0, m_ratio};
        if (a == 4'd1) return {20'd0, m_zmask};
        if (a == 4'd2) return m_cnt;
        if (a >= 4'd4 && a <= 4'd7) return m_cc[a[1:0]];
        return 24'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, 32'(rd_data), 32'(exp_read(rd_addr)));
            chk(cur_req, 32'({evt_wrap, evt_match}), 32'({m_wrap, m_evt}));
            if (evt_wrap) wrap_seen++;
        end
    end

    // slow tick source
    always @(posedge clk) begin
        #1;
        case (tick_mode)
            1:       lf_tick <= 1'b1;
            2:       lf_tick <= ($urandom % 3) == 0;
            default: lf_tick <= 1'b0;
        endcase
    end

    task automatic fire(input logic [3:0] t, input logic [NC-1:0] s);
        @(posedge clk); #1;
        {task_run, task_halt, task_zero, task_preload} = t;
        task_snap = s;
        @(posedge clk); #1;
        {task_run, task_halt, task_zero, task_preload} = 4'b0;
        task_snap = '0;
    endtask

    task automatic wreg(input logic [3:0] a, input logic [23:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; tick_mode = 0;
        idle(3);
        #1 rst_n = 1'b1;
    endtask

    localparam logic [3:0] T_RUN = 4'b1000, T_HALT = 4'b0100, T_ZERO = 4'b0010, T_PRE = 4'b0001;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        idle(3);
        #1 rst_n = 1'b1;

        // R1 reset values
        cur_req = "R1";
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); rd_addr = 4'(a);
            @(negedge clk); chk("R1", 32'(rd_data), 32'd0);
        end
        rd_addr = 4'd2;

        // R12 register map
        cur_req = "R12";
        wreg(4'd0, 24'hFFFABC);
        rd_addr = 4'd0; @(negedge clk); chk("R12", 32'(rd_data), 32'h000ABC);
        wreg(4'd2, 24'h123456);
        rd_addr = 4'd2; @(negedge clk); chk("R12", 32'(rd_data), 32'd0);
        wreg(4'd3, 24'h55);
        rd_addr = 4'd3; @(negedge clk); chk("R12", 32'(rd_data), 32'd0);
        rd_addr = 4'd2;

        // R3 rate with ratio 2
        cur_req = "R3";
        wreg(4'd0, 24'd2);
        tick_mode = 1;
        fire(T_RUN, '0);
        idle(30);
        @(negedge clk); chk("R3", 32'(rd_data), 32'(m_cnt));

        // R4 ratio write while counting has no effect
        cur_req = "R4";
        wreg(4'd0, 24'd0);
        idle(30);
        // R7 launch while counting ignored
        cur_req = "R7";
        fire(T_RUN, '0);
        idle(20);

        // R6 halt, hold, resume
        cur_req = "R6";
        fire(T_HALT, '0);
        idle(15);
        fire(T_RUN, '0);
        idle(15);

        // R11 zero, zero vs preload
        cur_req = "R11";
        fire(T_ZERO, '0);
        idle(10);
        fire(T_ZERO | T_PRE, '0);
        idle(10);
        @(negedge clk); chk("R11", 32'(rd_data < 24'd20), 32'd1);

        // R5 preload then wrap after 16 counts
        cur_req = "R5";
        do_reset();
        wreg(4'd0, 24'd0);
        tick_mode = 1;
        fire(T_RUN, '0);
        idle(4);
        wrap_seen = 0;
        fire(T_PRE, '0);
        idle(25);
        chk("R5", 32'(wrap_seen), 32'd1);

        // R2 wrap via random ticks with ratio 1
        cur_req = "R2";
        wreg(4'd0, 24'd1);
        tick_mode = 2;
        fire(T_PRE, '0);
        idle(120);

        // R8 compare, plus write equal to current count while halted
        cur_req = "R8";
        tick_mode = 1;
        fire(T_HALT, '0);
        idle(4);
        wreg(4'd4, m_cnt);
        wreg(4'd5, m_cnt + 24'd3);
        idle(5);
        fire(T_RUN, '0);
        idle(40);

        // R10 snapshot, snapshot beats write
        cur_req = "R10";
        fire(4'b0, 4'b0100);
        rd_addr = 4'd6; idle(3);
        @(posedge clk); #1;
        task_snap = 4'b1000; wr_en = 1'b1; wr_addr = 4'd7; wr_data = 24'hABCDEF;
        @(posedge clk); #1;
        task_snap = '0; wr_en = 1'b0;
        rd_addr = 4'd7;
        @(negedge clk); chk("R10", 32'(rd_data == 24'hABCDEF), 32'd0);
        rd_addr = 4'd2;

        // R9 auto-zero one tick after match
        cur_req = "R9";
        do_reset();
        wreg(4'd4, 24'd5);
        wreg(4'd1, 24'd1);
        tick_mode = 1;
        fire(T_RUN, '0);
        for (int k = 0; k < 40 && evt_match[0] !== 1'b1; k++) @(negedge clk);
        chk("R9", 32'(rd_data), 32'd5);
        @(negedge clk); chk("R9", 32'(rd_data), 32'd0);
        idle(30);

        // random mix
        cur_req = "R2,R3,R4,R6,R8,R9,R10,R11";
        tick_mode = 2;
        for (int it = 0; it < 6000; it++) begin
            @(posedge clk); #1;
            task_run     = ($urandom % 30) == 0;
            task_halt    = ($urandom % 60) == 0;
            task_zero    = ($urandom % 80) == 0;
            task_preload = ($urandom % 90) == 0;
            task_snap    = (($urandom % 40) == 0) ? 4'($urandom) : 4'b0;
            wr_en        = ($urandom % 12) == 0;
            wr_addr      = 4'($urandom % 8);
            wr_data      = (wr_addr == 4'd0) ? 24'($urandom % 3) : 24'($urandom % 48);
            rd_addr      = (($urandom % 4) == 0) ? 4'($urandom % 8) : 4'd2;
        end
        @(posedge clk); #1;
        {task_run, task_halt, task_zero, task_preload} = 4'b0;
        task_snap = '0; wr_en = 1'b0;
        idle(5);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule